// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is a cycle-level model of a small synchronous burst SRAM: 256 words of 36 bits, split into four 9-bit byte lanes. Each lane holds eight data bits and one parity bit. An access begins when the caller loads an external address with one of two start strobes.

- The processor-side strobe `proc_start_n` always begins a read. It is ignored completely while `sel1_n` is high.
- The controller-side strobe `ctrl_start_n` begins a read or a write, depending on the write decode. It is honoured whatever the selects are.

After an access has begun, the caller holds both strobes high. Each edge then either steps to the next beat of the four-beat burst or holds the current beat. The burst order is linear or interleaved, chosen by `interleave`.

A sleep input parks the device and preserves its contents. After sleep is released, two rising edges form a wake-up window in which no access may start.

Reads are flow-through: the word at the registered address appears on `dout` after the edge that sets that address. Write data is stored on the same edge that decodes the write.

The control state machine has five states:
- ST_IDLE: deselected.
- ST_READ: a read burst is active.
- ST_WRITE: a write burst is active.
- ST_SLEEP: parked.
- ST_WAKE: second edge of the wake-up window.

Its transitions are:
- sleep high on any edge: any state to ST_SLEEP.
- ST_SLEEP to ST_WAKE: sleep sampled low.
- ST_WAKE to ST_IDLE: the next edge, unconditionally.
- load, when the selects do not all agree: to ST_IDLE.
- processor-strobe load: to ST_READ.
- controller-strobe load: to ST_WRITE or ST_READ, following the write decode.
- continue or hold in ST_READ or ST_WRITE: to ST_WRITE or ST_READ, following the write decode of that edge.
- ST_IDLE with no load: stays in ST_IDLE.

Top module: `burst_sram_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `dout_en` and `wake_viol` are low, `dout` is zero and the state is ST_IDLE.
- R2: A load selects the device only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination on the load edge deselects the device, and `dout_en` stays low afterwards.
- R3: When `proc_start_n` is low while `sel1_n` is high, the processor strobe is ignored entirely. With `ctrl_start_n` high, the running burst continues or holds as if no strobe had been given.
- R4: A selected processor-strobe load begins a read of `addr`. After that edge, `dout` shows the stored word at `addr` and `dout_en` is high while `out_en_n` is low.
- R5: A selected controller-strobe load begins a write when the decode writes at least one lane, and a read otherwise. During a write burst `dout_en` is low.
- R6: With both strobes high in ST_READ or ST_WRITE, an edge with `advance_n`=0 moves to the next beat and an edge with `advance_n`=1 holds the current address. `advance_n` is ignored on a load edge.
- R7: Let `s` be the two low bits of the loaded address and `k` the beat count modulo 4. The low address bits are `s+k` mod 4 when `interleave`=0 and `s` XOR `k` when `interleave`=1. The upper address bits never change within a burst, and the fifth beat returns to the start.
- R8: `all_wr_n`=0 writes all four lanes, whatever `byte_wr_n` and `lane_wr_n` hold. Otherwise, `byte_wr_n`=0 writes each lane `i` whose `lane_wr_n[i]` is 0; lane `i` is bits `9i+8..9i`. Any other combination, including all lane enables high, is a read.
- R9: When both strobes are low on the same edge, the processor strobe wins and the access is a read, even if a write is decoded. Memory is unchanged.
- R10: While `sleep` is high, `dout_en` is low at once, without waiting for a clock edge. No edge writes or starts an access. Stored words are preserved across sleep.
- R11: Once `sleep` is low, the first two rising edges are a wake-up window. A start strobe on those edges is ignored, and `wake_viol` is high for the cycle that follows. A strobe while `sleep` is high raises no flag. The third edge accepts a start.
- R12: `out_en_n` acts without a clock: when it is high, `dout_en` is low, and it returns high as soon as `out_en_n` falls during a read.
- R13: Whenever `dout_en` is low, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 8 | External word address |
| sel1_n | input | 1 | Select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Select 2, active high |
| sel3_n | input | 1 | Select 3, active low |
| proc_start_n | input | 1 | Processor-side start strobe, active low |
| ctrl_start_n | input | 1 | Controller-side start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| byte_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| sleep | input | 1 | Power-down request, active high |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not enabled |
| dout_en | output | 1 | Read data valid and driven |
| wake_viol | output | 1 | Start strobe seen in the wake-up window |

## Verification
The following properties are checked on every cycle:
- An enabled output always implies `out_en_n` low and `sleep` low.
- A `sleep` value sampled high leaves the output disabled on the next cycle.
- A `wake_viol` pulse always follows a strobe.
- A controller-strobe load with `sel1_n` high, or a decoded controller-strobe write, never leaves the output enabled.
- A selected processor-strobe load yields a driven read unless the output is disabled or the load was refused in the wake-up window.
- A hold edge leaves the data stable.

Only the bench scenarios can show the rest:
- The burst address sequences in both orders, over every start address.
- The exact merge of partial lane writes.
- Strobe priority, and preservation of contents across sleep.
- The exact edge at which the wake-up window ends.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_SLEEP,
        ST_WAKE
    } ctl_state_e;
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import sram_burst_pkg::*;
(
    input  logic [BURST_W-1:0] start_lo,
    input  logic [BURST_W-1:0] beat,
    input  logic               interleave,
    output logic [BURST_W-1:0] lo
);
    // Interleaved order flips bits of the start, linear order adds with wrap.
    always_comb begin
        if (interleave) lo = start_lo ^ beat;
        else            lo = start_lo + beat;
    end
endmodule

// File: rtl/write_decode.sv
module write_decode #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_mask
);
    // Global write overrides everything; lane writes need the qualifier.
    always_comb begin
        if (!all_wr_n)       lane_mask = '1;
        else if (!byte_wr_n) lane_mask = ~lane_wr_n;
        else                 lane_mask = '0;
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter  int ADDR_W = 8,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_mask[l]) begin
                    mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Flow-through read port.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import sram_burst_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              proc_start_n,
    input  logic              ctrl_start_n,
    input  logic              advance_n,
    input  logic              out_en_n,
    input  logic              all_wr_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              sleep,
    input  logic              interleave,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              wake_viol
);
    ctl_state_e state_q, state_d;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] beat_q;
    logic [BURST_W-1:0] beat_nxt;
    logic               viol_q;
    logic               viol_d;

    logic in_window;
    logic any_strobe;
    logic proc_take;
    logic load;
    logic selected;
    logic active;
    logic step;
    logic wr_any;
    logic wr_fire;

    logic [LANES-1:0]   lane_mask;
    logic [BURST_W-1:0] lo_cur;
    logic [BURST_W-1:0] lo_nxt;
    logic [ADDR_W-1:0]  cur_addr;
    logic [ADDR_W-1:0]  nxt_addr;
    logic [ADDR_W-1:0]  wr_addr;
    logic [DATA_W-1:0]  rd_word;

    // Strobe qualification
    assign in_window  = (state_q == ST_SLEEP) || (state_q == ST_WAKE);
    assign any_strobe = !proc_start_n || !ctrl_start_n;
    assign proc_take  = !proc_start_n && !sel1_n;
    assign load       = !in_window && (proc_take || !ctrl_start_n);
    assign selected   = !sel1_n && sel2 && !sel3_n;
    assign active     = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign step       = !sleep && !load && active && !advance_n;

    // Burst address generation
    assign beat_nxt = beat_q + 1'b1;

    burst_addr_gen u_seq_cur (
        .start_lo   (base_q[BURST_W-1:0]),
        .beat       (beat_q),
        .interleave (interleave),
        .lo         (lo_cur)
    );

    burst_addr_gen u_seq_nxt (
        .start_lo   (base_q[BURST_W-1:0]),
        .beat       (beat_nxt),
        .interleave (interleave),
        .lo         (lo_nxt)
    );

    assign cur_addr = {base_q[ADDR_W-1:BURST_W], lo_cur};
    assign nxt_addr = {base_q[ADDR_W-1:BURST_W], lo_nxt};

    // Write decode and array
    write_decode #(.LANES(LANES)) u_wdec (
        .all_wr_n  (all_wr_n),
        .byte_wr_n (byte_wr_n),
        .lane_wr_n (lane_wr_n),
        .lane_mask (lane_mask)
    );

    assign wr_any  = |lane_mask;
    assign wr_fire = !sleep && wr_any &&
                     ((load && selected && !proc_take) || (!load && active));
    assign wr_addr = load ? addr : (step ? nxt_addr : cur_addr);

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (wr_fire),
        .wr_mask (lane_mask),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (cur_addr),
        .rd_data (rd_word)
    );

    // Next-state decode
    always_comb begin
        state_d = ST_IDLE;
        if (sleep) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_SLEEP: state_d = ST_WAKE;
                ST_WAKE:  state_d = ST_IDLE;
                ST_IDLE, ST_READ, ST_WRITE: begin
                    if (load) begin
                        if (!selected)      state_d = ST_IDLE;
                        else if (proc_take) state_d = ST_READ;
                        else                state_d = wr_any ? ST_WRITE : ST_READ;
                    end else if (active) begin
                        state_d = wr_any ? ST_WRITE : ST_READ;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign viol_d = !sleep && in_window && any_strobe;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            viol_q  <= viol_d;
        end
    end

    // Address and beat registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (!sleep && load && selected) begin
            base_q <= addr;
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_nxt;
        end
    end

    // Outputs
    always_comb begin
        dout_en   = (state_q == ST_READ) && !out_en_n && !sleep;
        dout      = dout_en ? rd_word : '0;
        wake_viol = viol_q;
    end
endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              proc_start_n,
    input logic              ctrl_start_n,
    input logic              advance_n,
    input logic              out_en_n,
    input logic              all_wr_n,
    input logic              byte_wr_n,
    input logic              sleep,
    input logic              interleave,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              wake_viol
);
    p_oe_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!out_en_n && !sleep));

    p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) |-> !dout_en);

    p_viol_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_viol |-> $past(!proc_start_n || !ctrl_start_n));

    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_start_n && sel1_n) |=> !dout_en);

    p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_start_n && proc_start_n && !all_wr_n) |=> !dout_en);

    p_start_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_start_n && !sel1_n && sel2 && !sel3_n && !sleep)
        |=> (dout_en || out_en_n || sleep || wake_viol));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && proc_start_n && ctrl_start_n && advance_n &&
         all_wr_n && byte_wr_n && !sleep)
        |=> (!dout_en || $stable(dout) || !$stable(interleave)));
endmodule

bind burst_sram_ctrl burst_sram_checker #(.DATA_W(DATA_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel1_n       (sel1_n),
    .sel2         (sel2),
    .sel3_n       (sel3_n),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .advance_n    (advance_n),
    .out_en_n     (out_en_n),
    .all_wr_n     (all_wr_n),
    .byte_wr_n    (byte_wr_n),
    .sleep        (sleep),
    .interleave   (interleave),
    .dout         (dout),
    .dout_en      (dout_en),
    .wake_viol    (wake_viol)
);

// File: tb/test_burst_sram_ctrl.sv
module test_burst_sram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          sel1_n, sel2, sel3_n;
    logic          proc_start_n, ctrl_start_n, advance_n, out_en_n;
    logic          all_wr_n, byte_wr_n;
    logic [3:0]    lane_wr_n;
    logic          sleep, interleave;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          wake_viol;

    logic [DW-1:0] model [256];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    burst_sram_ctrl i_burst_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
        .advance_n(advance_n), .out_en_n(out_en_n),
        .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
        .sleep(sleep), .interleave(interleave), .din(din),
        .dout(dout), .dout_en(dout_en), .wake_viol(wake_viol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(input logic [7:0] a);
        return {a, ~a, a ^ 8'h5A, a + 8'h33, 4'hC};
    endfunction

    task automatic idle();
        proc_start_n = 1; ctrl_start_n = 1; advance_n = 1;
        all_wr_n = 1; byte_wr_n = 1; lane_wr_n = 4'hF;
        sel1_n = 0; sel2 = 1; sel3_n = 0; out_en_n = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a);
        idle(); addr = a; proc_start_n = 0; tick(); idle();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        idle(); addr = 0; din = 0; sleep = 0; interleave = 0; rst_n = 0;
        repeat (3) tick();
        check("R1 dout_en in reset", {35'd0, dout_en}, 0);
        check("R1 wake_viol in reset", {35'd0, wake_viol}, 0);
        check("R13 dout zero in reset", dout, 0);
        rst_n = 1; tick();
        check("R1 dout_en after reset", {35'd0, dout_en}, 0);

        // R5/R8: fill with global writes
        for (int a = 0; a < 256; a++) begin
            idle(); addr = a[7:0]; ctrl_start_n = 0; all_wr_n = 0; din = pat(a[7:0]);
            tick();
            model[a] = pat(a[7:0]);
            check("R5 write cycle quiet", {35'd0, dout_en}, 0);
        end
        idle(); tick();

        // R4/R6/R7: burst sweep both orders, advance held low on the load edge
        for (int m = 0; m < 2; m++) begin
            interleave = m[0];
            for (int a = 0; a < 256; a++) begin
                logic [7:0] av;
                av = a[7:0];
                idle(); addr = av; proc_start_n = 0; advance_n = 0;
                tick();
                check("R4 start read", dout, model[av]);
                check("R6 advance ignored on load / R4 enable", {35'd0, dout_en}, 1);
                proc_start_n = 1;
                for (int k = 1; k <= 4; k++) begin
                    logic [1:0] lo;
                    lo = m[0] ? (av[1:0] ^ k[1:0]) : (av[1:0] + k[1:0]);
                    tick();
                    check("R7 burst order", dout, model[{av[7:2], lo}]);
                end
            end
        end
        interleave = 0;

        // R6 hold
        read_at(8'd17);
        tick(); check("R6 hold", dout, model[17]);
        tick(); check("R6 hold again", dout, model[17]);
        advance_n = 0; tick(); advance_n = 1;
        check("R6 step after hold", dout, model[18]);

        // R3 blocked processor strobe
        read_at(8'd40);
        addr = 8'd99; proc_start_n = 0; sel1_n = 1; tick(); idle();
        check("R3 blocked strobe keeps data", dout, model[40]);
        check("R3 still enabled", {35'd0, dout_en}, 1);

        // R2 select combinations
        for (int s = 0; s < 8; s++) begin
            idle(); sel1_n = s[0]; sel2 = s[1]; sel3_n = s[2];
            addr = 8'd60; ctrl_start_n = 0; tick(); idle();
            check("R2 select decode", {35'd0, dout_en}, (s == 2) ? 36'd1 : 36'd0);
            if (s == 2) check("R2 selected read", dout, model[60]);
        end

        // R8 lane writes, all masks
        for (int mk = 0; mk < 16; mk++) begin
            logic [DW-1:0] old_w, new_w, exp_w;
            old_w = pat(mk[7:0]); new_w = ~old_w;
            idle(); addr = 8'd200; ctrl_start_n = 0; all_wr_n = 0; din = old_w; tick();
            idle(); addr = 8'd200; ctrl_start_n = 0; byte_wr_n = 0;
            lane_wr_n = mk[3:0]; din = new_w; tick();
            check("R8 lane write quiet / all-high reads",
                  {35'd0, dout_en}, (mk == 15) ? 36'd1 : 36'd0);
            exp_w = old_w;
            for (int l = 0; l < 4; l++)
                if (!mk[l]) exp_w[l*9 +: 9] = new_w[l*9 +: 9];
            model[200] = exp_w;
            read_at(8'd200);
            check("R8 lane merge", dout, exp_w);
        end
        idle(); addr = 8'd200; ctrl_start_n = 0; all_wr_n = 0; byte_wr_n = 0;
        lane_wr_n = 4'hF; din = pat(8'd7); tick();
        model[200] = pat(8'd7);
        read_at(8'd200);
        check("R8 global overrides lanes", dout, pat(8'd7));
        idle(); addr = 8'd200; ctrl_start_n = 0; lane_wr_n = 4'h0; din = 0; tick(); idle();
        check("R8 lanes without qualifier read", dout, model[200]);
        check("R8 read enabled", {35'd0, dout_en}, 1);

        // R9 priority
        idle(); addr = 8'd123; proc_start_n = 0; ctrl_start_n = 0; all_wr_n = 0; din = 0;
        tick(); idle();
        check("R9 processor strobe wins", dout, model[123]);
        check("R9 enabled", {35'd0, dout_en}, 1);
        read_at(8'd123);
        check("R9 memory unchanged", dout, model[123]);

        // R6 write burst continue/hold
        idle(); addr = 8'd80; ctrl_start_n = 0; all_wr_n = 0; din = 36'h1_1111_1111; tick();
        idle(); all_wr_n = 0; advance_n = 0; din = 36'h2_2222_2222; tick();
        check("R5 write burst quiet", {35'd0, dout_en}, 0);
        idle(); all_wr_n = 0; din = 36'h3_3333_3333; tick();
        idle(); all_wr_n = 0; advance_n = 0; din = 36'h4_4444_4444; tick();
        idle();
        model[80] = 36'h1_1111_1111; model[81] = 36'h3_3333_3333; model[82] = 36'h4_4444_4444;
        read_at(8'd80);
        check("R6 write beat 0", dout, model[80]);
        advance_n = 0; tick(); check("R6 write beat 1 held", dout, model[81]);
        tick(); advance_n = 1; check("R6 write beat 2", dout, model[82]);

        // R12/R13 output enable
        read_at(8'd5);
        out_en_n = 1; #1;
        check("R12 oe off", {35'd0, dout_en}, 0);
        check("R13 dout zero", dout, 0);
        out_en_n = 0; #1;
        check("R12 oe on", {35'd0, dout_en}, 1);

        // R10/R11 sleep and wake window
        read_at(8'd9);
        sleep = 1; #1;
        check("R10 immediate quiet", {35'd0, dout_en}, 0);
        addr = 8'd9; ctrl_start_n = 0; all_wr_n = 0; din = 0; tick();
        check("R11 no flag while asleep", {35'd0, wake_viol}, 0);
        idle(); tick(); tick();
        sleep = 0;
        addr = 8'd9; proc_start_n = 0; tick();
        check("R11 first window edge ignored", {35'd0, dout_en}, 0);
        check("R11 first window flag", {35'd0, wake_viol}, 1);
        idle(); addr = 8'd9; ctrl_start_n = 0; tick();
        check("R11 second window edge ignored", {35'd0, dout_en}, 0);
        check("R11 second window flag", {35'd0, wake_viol}, 1);
        idle(); addr = 8'd9; proc_start_n = 0; tick(); idle();
        check("R11 third edge accepted", {35'd0, dout_en}, 1);
        check("R10 contents preserved", dout, model[9]);
        check("R11 flag cleared", {35'd0, wake_viol}, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule